// File: doc/BRIEF.md
# Integer Add, Subtract and Negate Unit with Condition Flags

This block does integer arithmetic on two operands, 8 bits wide by default. Four operations are available: add, add with the stored carry, subtract and negate. All four share one ripple-carry adder. Subtract and negate reach that adder by inverting the second operand and setting the carry-in to one. Negate also forces the first operand to zero. Every result comes with four condition flags: zero, negative, carry and signed overflow. Signed overflow is taken from the carry chain itself, by comparing the carry into the top bit with the carry out of it.

The arithmetic path is combinational. The result and the next flag values therefore appear in the same cycle as the operands. A four-bit flag register keeps the last accepted flags. It loads only while the write strobe is high, and a synchronous reset clears it. Add-with-carry reads its carry-in from the stored carry bit of that register.

There is no control sequence in this block, so there are no states or transitions to name. The only storage is the flag register, which has two behaviours: on a strobe it captures the next flags, and otherwise it holds.

Top module: `arith_flags_unit`

## Requirements
- R1: With op_sel = 2'b00 (add), result = (op_a + op_b) mod 2^W, and flag C is the carry out of the top bit, with a carry-in of 0.
- R2: With op_sel = 2'b01 (add with carry), result = (op_a + op_b + Cq) mod 2^W, where Cq is the stored carry, flags_q[1].
- R3: With op_sel = 2'b10 (subtract), result = (op_a − op_b) mod 2^W. C is the raw adder carry out, so C = 1 exactly when op_a ≥ op_b unsigned (no borrow).
- R4: With op_sel = 2'b11 (negate), result = (0 − op_b) mod 2^W and op_a is ignored. C = 1 exactly when op_b = 0.
- R5: V is 1 exactly when the mathematically exact signed result of the operation lies outside the W-bit two's complement range, for every operation and every operand pair.
- R6: For subtract, V equals (the signs of op_a and op_b differ) AND (the sign of the result differs from the sign of op_a).
- R7: Negating the most negative value (0x80 at 8 bits) returns that same value with V = 1. Negating zero returns zero with V = 0, C = 1 and Z = 1.
- R8: Z = 1 exactly when the result is all zeros, and N equals the top bit of the result.
- R9: flags_nxt = {N, Z, C, V} at bit positions 3..0. It is valid in the same cycle as the operands, with no clock edge in between.
- R10: On a rising clock edge with flag_we = 1, flags_q takes the value of flags_nxt. With flag_we = 0, flags_q holds its value.
- R11: On a rising clock edge with rst = 1, flags_q clears to 4'b0000. This takes priority over flag_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high, clears the stored flags |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_sel | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 negate |
| flag_we | input | 1 | Flag register write strobe |
| result | output | W | Arithmetic result, combinational |
| flags_nxt | output | 4 | Next flags {N, Z, C, V}, combinational |
| flags_q | output | 4 | Stored flags {N, Z, C, V} |

## Verification
The combinational checks in the flag logic assume the operands and op_sel are settled, two-valued levels whenever the result is observed. The register checks assume flag_we is sampled only at clock edges. The bench changes the operands and op_sel while flag_we is low, so a combinational sweep never disturbs the stored flags. It changes flag_we and any operands meant for a register load only on the falling edge, half a period away from the capturing edge. Add-with-carry is swept twice, once for each stored carry value, and each carry value is loaded through a prior add before its sweep begins.

// File: rtl/afu_pkg.sv
package afu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_NEG = 2'b11
    } afu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } afu_flags_t;

    localparam int unsigned FLAG_BITS = 4;

endpackage

// File: rtl/afu_operand_mux.sv
module afu_operand_mux
    import afu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  afu_op_e        op,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic           c_stored,
    output logic [W-1:0]   a_eff,
    output logic [W-1:0]   b_eff,
    output logic           c_in
);

    localparam logic [W-1:0] ZERO_W = '0;

    always_comb begin
        a_eff = a_in;
        b_eff = b_in;
        c_in  = 1'b0;
        unique case (op)
            OP_ADD: begin
                c_in = 1'b0;
            end
            OP_ADC: begin
                c_in = c_stored;
            end
            OP_SUB: begin
                b_eff = ~b_in;
                c_in  = 1'b1;
            end
            OP_NEG: begin
                a_eff = ZERO_W;
                b_eff = ~b_in;
                c_in  = 1'b1;
            end
            default: begin
                c_in = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/afu_ripple_adder.sv
module afu_ripple_adder #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         c_into_msb,
    output logic         c_out
);

    logic [W:0] chain;

    assign chain[0] = c_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        assign p          = x[i] ^ y[i];
        assign sum[i]     = p ^ chain[i];
        assign chain[i+1] = (x[i] & y[i]) | (p & chain[i]);
    end

    assign c_into_msb = chain[W-1];
    assign c_out      = chain[W];

endmodule

// File: rtl/afu_flag_gen.sv
module afu_flag_gen
    import afu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  afu_op_e        op,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic [W-1:0]   sum,
    input  logic           c_into_msb,
    input  logic           c_out,
    output afu_flags_t     flags
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ZERO_W   = '0;

    always_comb begin
        flags.neg   = sum[W-1];
        flags.zero  = (sum == ZERO_W);
        flags.carry = c_out;
        flags.ovf   = c_into_msb ^ c_out;
    end

    // The sign rule for subtraction is computed separately from the carry chain.
    always_comb begin
        if (op == OP_SUB) begin
            p_sub_sign_rule_r6: assert (flags.ovf ==
                ((a_in[W-1] != b_in[W-1]) && (sum[W-1] != a_in[W-1])));
        end
    end

    always_comb begin
        if (op == OP_NEG && b_in == MOST_NEG) begin
            p_neg_most_negative_r7: assert (sum == MOST_NEG && flags.ovf);
        end
    end

    always_comb begin
        if (op == OP_NEG && b_in == ZERO_W) begin
            p_neg_zero_r7: assert (flags.zero && flags.carry && !flags.ovf);
        end
    end

    always_comb begin
        if (op == OP_ADD || op == OP_ADC) begin
            p_add_sign_rule_r5: assert (flags.ovf ==
                ((a_in[W-1] == b_in[W-1]) && (sum[W-1] != a_in[W-1])));
        end
    end

endmodule

// File: rtl/afu_flag_reg.sv
module afu_flag_reg
    import afu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  afu_flags_t d,
    output afu_flags_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/arith_flags_unit.sv
module arith_flags_unit
    import afu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [1:0]    op_sel,
    input  logic          flag_we,
    output logic [W-1:0]  result,
    output logic [3:0]    flags_nxt,
    output logic [3:0]    flags_q
);

    afu_op_e    op;
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    logic         c_in;
    logic         c_into_msb;
    logic         c_out;
    afu_flags_t   f_next;
    afu_flags_t   f_store;

    assign op = afu_op_e'(op_sel);

    afu_operand_mux #(.W(W)) u_mux (
        .op       (op),
        .a_in     (op_a),
        .b_in     (op_b),
        .c_stored (f_store.carry),
        .a_eff    (a_eff),
        .b_eff    (b_eff),
        .c_in     (c_in)
    );

    afu_ripple_adder #(.W(W)) u_add (
        .x          (a_eff),
        .y          (b_eff),
        .c_in       (c_in),
        .sum        (result),
        .c_into_msb (c_into_msb),
        .c_out      (c_out)
    );

    afu_flag_gen #(.W(W)) u_flags (
        .op         (op),
        .a_in       (op_a),
        .b_in       (op_b),
        .sum        (result),
        .c_into_msb (c_into_msb),
        .c_out      (c_out),
        .flags      (f_next)
    );

    afu_flag_reg u_freg (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (f_next),
        .q   (f_store)
    );

    assign flags_nxt = f_next;
    assign flags_q   = f_store;

endmodule

// File: tb/arith_flags_unit_test.sv
module arith_flags_unit_test;

    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int MASK       = (1 << W) - 1;
    localparam int HALF       = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [1:0]   op_sel;
    logic         flag_we;
    logic [W-1:0] result;
    logic [3:0]   flags_nxt;
    logic [3:0]   flags_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    arith_flags_unit #(.W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sel    (op_sel),
        .flag_we   (flag_we),
        .result    (result),
        .flags_nxt (flags_nxt),
        .flags_q   (flags_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int to_signed(int v);
        return (v >= HALF) ? v - (1 << W) : v;
    endfunction

    // Returns {result, N, Z, C, V} from wider integer arithmetic.
    function automatic logic [W+3:0] model(int op, int a, int b, int cin);
        int u;
        int s;
        int r;
        logic n, z, c, v;
        case (op)
            0: begin u = a + b;                s = to_signed(a) + to_signed(b); end
            1: begin u = a + b + cin;          s = to_signed(a) + to_signed(b) + cin; end
            2: begin u = a + (MASK - b) + 1;   s = to_signed(a) - to_signed(b); end
            default: begin u = (MASK - b) + 1; s = -to_signed(b); end
        endcase
        r = u & MASK;
        c = ((u >> W) & 1) != 0;
        v = (s > HALF - 1) || (s < -HALF);
        n = ((r >> (W - 1)) & 1) != 0;
        z = (r == 0);
        return {r[W-1:0], n, z, c, v};
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R1/R5/R8/R9";
            1: return "R2/R5/R8/R9";
            2: return "R3/R6/R5/R8/R9";
            default: return "R4/R7/R5/R8/R9";
        endcase
    endfunction

    task automatic check_comb(int op, int a, int b, int cin);
        logic [W+3:0] exp;
        exp = model(op, a, b, cin);
        checks++;
        if (result !== exp[W+3:4] || flags_nxt !== exp[3:0]) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h: got res=%02h flags=%04b expected res=%02h flags=%04b",
                     tag_of(op), op, a, b, result, flags_nxt, exp[W+3:4], exp[3:0]);
        end
    endtask

    task automatic check_q(string req, logic [3:0] exp);
        checks++;
        if (flags_q !== exp) begin
            errors++;
            $display("FAIL %s flags_q got %04b expected %04b", req, flags_q, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Loads a known carry through an add, at the falling edge.
    task automatic load_carry(bit cval);
        @(negedge clk);
        op_sel  = 2'b00;
        op_a    = cval ? W'(MASK) : '0;
        op_b    = cval ? W'(1) : '0;
        flag_we = 1'b1;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [3:0]   model_q;
        logic [W+3:0] e;
        int unsigned  seed;
        seed    = 32'd2718;
        void'($urandom(seed));
        rst     = 1'b1;
        flag_we = 1'b1;
        op_sel  = 2'b00;
        op_a    = W'(MASK);
        op_b    = W'(1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_q("R11", 4'b0000);
        rst = 1'b0;
        flag_we = 1'b0;

        // R7 directed corners
        op_sel = 2'b11; op_b = W'(HALF); op_a = W'(8'h55); #1;
        check_comb(3, 8'h55, HALF, 0);
        op_b = '0; #1;
        check_comb(3, 8'h55, 0, 0);
        // R3 equal operands give zero, no borrow
        op_sel = 2'b10; op_a = W'(8'h3C); op_b = W'(8'h3C); #1;
        check_comb(2, 8'h3C, 8'h3C, 0);

        // Exhaustive sweeps for add, subtract, negate
        for (int op = 0; op < 4; op++) begin
            if (op == 1) continue;
            op_sel = op[1:0];
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    op_a = W'(a); op_b = W'(b); #1;
                    check_comb(op, a, b, 0);
                end
            end
        end

        // R2 sweep with each stored carry
        for (int cv = 0; cv < 2; cv++) begin
            load_carry(cv[0]);
            check_q("R10", cv[0] ? 4'b0110 : 4'b0100);
            op_sel = 2'b01;
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    op_a = W'(a); op_b = W'(b); #1;
                    check_comb(1, a, b, cv);
                end
            end
        end

        // Random register traffic: R10 load/hold, R11 reset priority
        @(negedge clk);
        model_q = flags_q;
        for (int i = 0; i < 3000; i++) begin
            op_sel  = 2'($urandom);
            op_a    = W'($urandom);
            op_b    = W'($urandom);
            flag_we = ($urandom % 2) == 1;
            rst     = ($urandom % 40) == 0;
            #1;
            e = model(int'(op_sel), int'(op_a), int'(op_b), int'(model_q[1]));
            check_comb(int'(op_sel), int'(op_a), int'(op_b), int'(model_q[1]));
            if (rst)          model_q = 4'b0000;
            else if (flag_we) model_q = e[3:0];
            @(negedge clk);
            check_q(rst ? "R11" : "R10", model_q);
        end
        rst = 1'b0;
        flag_we = 1'b0;
        finish_run();
    end

endmodule